// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block opens and closes the transmission gates of the eight traffic classes on several egress ports, all on one time schedule. Each port has its own short list of entries. An entry pairs an 8-bit open-gate mask with a hold time. A port engine starts its list at a programmed absolute start time. It steps through the list as each hold time runs out and goes back to the first entry after the last one. The shared time input is a counter of 200 ns slots from the synchronised clock. Gate events can only land on slot boundaries.

Gate transitions on different ports must not land in the same slot. The same rule applies to an engine that drives an ingress policing gate. The block watches for this collision and raises a sticky error that names a port involved. Software fills the entry lists through a simple write port. It sets the start time, the list length and a run enable for each port as static inputs.

Top module: `gate_sched`

## Requirements
- R1: After reset every port's gate mask is 8'hFF, `conflict_o` is 0 and `conflict_port_o` is 0. Every table entry resets to mask 8'hFF and duration 0.
- R2: While a port's `run_i` bit is low, or before its first start, its gate mask is 8'hFF. The first start happens in the clock cycle in which `time_i >= base_time` for that port.
- R3: At the clock edge where a port first samples `time_i >= base_time`, the port loads entry 0. Its mask appears on the gate output from that edge onward. Bit k of a mask opens traffic class k.
- R4: An entry that starts at slot S with duration D stays on the output until the edge that samples `time_i >= S + D`. At that edge the next entry's mask appears. The next entry is timed from S + D, not from the sampled time.
- R5: After entry `last_idx` expires, the port returns to entry 0. The new cycle starts at the previous cycle start plus the sum of the effective durations of entries 0 through `last_idx`.
- R6: A stored duration of 0 acts as a duration of one slot.
- R7: Driving `run_i` low returns that port to 8'hFF at the next edge. Raising it again restarts the list from entry 0 at the port's base time.
- R8: A gate event is a start or an entry change. If two or more ports have a gate event at the same clock edge, `conflict_o` is 1 after that edge and stays 1 until it is cleared.
- R9: `conflict_port_o` latches the lowest-numbered port of the collision that set the flag. It does not change on later collisions while the flag stays set.
- R10: A pulse on `err_clr_i` clears `conflict_o` at that edge. If a collision happens at the same edge, the flag stays set and `conflict_port_o` latches the new collision's lowest port.
- R11: A write with `wr_en_i` high stores `wr_mask_i` and `wr_dur_i` (in slots) at entry `wr_idx_i` of port `wr_port_i`. A write whose port number is NUM_PORTS or larger changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_i | input | TIME_W | Synchronised time, counted in 200 ns slots |
| wr_en_i | input | 1 | Entry write strobe |
| wr_port_i | input | PORT_W | Port number of the write |
| wr_idx_i | input | IDX_W | Entry number of the write |
| wr_mask_i | input | 8 | Gate mask to store, bit k = class k |
| wr_dur_i | input | DUR_W | Duration to store, in slots |
| run_i | input | NUM_PORTS | Per-port schedule enable |
| base_time_i | input | NUM_PORTS*TIME_W | Per-port start slot, port p at bits [p*TIME_W +: TIME_W] |
| last_idx_i | input | NUM_PORTS*IDX_W | Per-port index of the final list entry |
| err_clr_i | input | 1 | Clears the collision flag |
| gate_o | output | NUM_PORTS*8 | Per-port open-gate mask, port p at bits [p*8 +: 8] |
| conflict_o | output | 1 | Sticky collision flag |
| conflict_port_o | output | PORT_W | Lowest port of the latched collision |

## Verification
The hardest case to reach is a clear pulse that lands on the same edge as a new collision. The flag must then stay set while the latched port changes. The stimulus first creates a collision between ports 1 and 2 and stops all engines. It then starts ports 0 and 2 on a shared base time and times `err_clr_i` to the cycle that samples that base. The set-wins rule and the re-latch show up together at the ports. Durations of zero, list wrap-around and restart after a run drop are driven with known slot numbers, so each transition is checked on its exact slot.

// File: rtl/gs_pkg.sv
// Shared constants and helpers for the gate scheduler.
// Assumes eight traffic classes per port.
package gs_pkg;
    localparam int NUM_TC = 8;
    typedef logic [NUM_TC-1:0] gate_mask_t;
    localparam gate_mask_t ALL_OPEN = '1;
endpackage

// File: rtl/gs_entry_table.sv
// Per-port schedule list: DEPTH entries of {mask, duration}, written one at
// a time and read asynchronously by the port engine.
// Assumes the writer targets this table only when wr_en is high.
module gs_entry_table
    import gs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DUR_W = 20,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  gate_mask_t       wr_mask,
    input  logic [DUR_W-1:0] wr_dur,
    input  logic [IDX_W-1:0] rd_idx,
    output gate_mask_t       rd_mask,
    output logic [DUR_W-1:0] rd_dur
);
    gate_mask_t       mask_q [DEPTH];
    logic [DUR_W-1:0] dur_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Store one entry when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[e] <= ALL_OPEN;
                dur_q[e]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                mask_q[e] <= wr_mask;
                dur_q[e]  <= wr_dur;
            end
        end
    end

    // Read port used by the engine.
    always_comb begin
        rd_mask = mask_q[rd_idx];
        rd_dur  = dur_q[rd_idx];
    end
endmodule

// File: rtl/gs_port_engine.sv
// Walks one port's list: starts at base time, holds each entry for its
// duration (0 acts as 1 slot), wraps after last_idx, and reports a gate
// event (fire) on every start or entry change.
// Assumes time advances monotonically and last_idx < DEPTH.
module gs_port_engine
    import gs_pkg::*;
#(
    parameter int TIME_W = 32,
    parameter int DUR_W  = 20,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] base_time,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  rd_idx,
    input  gate_mask_t        rd_mask,
    input  logic [DUR_W-1:0]  rd_dur,
    output logic              fire,
    output gate_mask_t        gate
);
    logic              started_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TIME_W-1:0] event_at_q;
    gate_mask_t        gate_q;

    logic              start_hit, step_hit;
    logic [TIME_W-1:0] eff_dur, origin;

    // Decide whether this edge starts the list or moves to the next entry.
    always_comb begin
        start_hit = run && !started_q && (time_now >= base_time);
        step_hit  = run &&  started_q && (time_now >= event_at_q);
        fire      = start_hit || step_hit;
        if (start_hit || (idx_q == last_idx)) rd_idx = '0;
        else                                 rd_idx = idx_q + 1'b1;
        eff_dur = (rd_dur == '0) ? TIME_W'(1) : TIME_W'(rd_dur);
        origin  = start_hit ? base_time : event_at_q;
    end

    // Hold the position in the list and the current gate mask.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            started_q  <= 1'b0;
            idx_q      <= '0;
            event_at_q <= '0;
            gate_q     <= ALL_OPEN;
        end else if (fire) begin
            started_q  <= 1'b1;
            idx_q      <= rd_idx;
            event_at_q <= origin + eff_dur;
            gate_q     <= rd_mask;
        end
    end

    assign gate = gate_q;
endmodule

// File: rtl/gs_conflict.sv
// Flags gate events from two or more ports at the same edge; sticky until
// cleared, with the lowest colliding port latched. Set wins over clear.
// Assumes fire is a per-port single-cycle event strobe.
module gs_conflict #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] fire,
    input  logic                 clr,
    output logic                 flag,
    output logic [PORT_W-1:0]    port
);
    logic              hit;
    logic [PORT_W-1:0] low_port;

    // Detect a collision and find its lowest-numbered port.
    always_comb begin
        hit      = ($countones(fire) > 1);
        low_port = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (fire[i]) low_port = PORT_W'(i);
        end
    end

    // Sticky flag and latched port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            port <= '0;
        end else if (hit) begin
            flag <= 1'b1;
            if (!flag || clr) port <= low_port;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/gate_sched.sv
// Top: one entry table and one engine per port plus the shared collision
// detector. Time is counted in 200 ns slots.
// Assumes DEPTH is a power of two and the cycle inputs are static while run.
module gate_sched
    import gs_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int DEPTH     = 4,
    parameter int TIME_W    = 32,
    parameter int DUR_W     = 20,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TIME_W-1:0]             time_i,
    input  logic                          wr_en_i,
    input  logic [PORT_W-1:0]             wr_port_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [NUM_TC-1:0]             wr_mask_i,
    input  logic [DUR_W-1:0]              wr_dur_i,
    input  logic [NUM_PORTS-1:0]          run_i,
    input  logic [NUM_PORTS*TIME_W-1:0]   base_time_i,
    input  logic [NUM_PORTS*IDX_W-1:0]    last_idx_i,
    input  logic                          err_clr_i,
    output logic [NUM_PORTS*NUM_TC-1:0]   gate_o,
    output logic                          conflict_o,
    output logic [PORT_W-1:0]             conflict_port_o
);
    logic [NUM_PORTS-1:0] port_fire;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic             sel;
        logic [IDX_W-1:0] rd_idx;
        gate_mask_t       rd_mask;
        logic [DUR_W-1:0] rd_dur;
        gate_mask_t       gate;

        assign sel = wr_en_i && (wr_port_i == PORT_W'(p));

        gs_entry_table #(.DEPTH(DEPTH), .DUR_W(DUR_W)) u_tab (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel),
            .wr_idx (wr_idx_i),
            .wr_mask(wr_mask_i),
            .wr_dur (wr_dur_i),
            .rd_idx (rd_idx),
            .rd_mask(rd_mask),
            .rd_dur (rd_dur)
        );

        gs_port_engine #(.TIME_W(TIME_W), .DUR_W(DUR_W), .IDX_W(IDX_W)) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_i[p]),
            .time_now (time_i),
            .base_time(base_time_i[p*TIME_W +: TIME_W]),
            .last_idx (last_idx_i[p*IDX_W +: IDX_W]),
            .rd_idx   (rd_idx),
            .rd_mask  (rd_mask),
            .rd_dur   (rd_dur),
            .fire     (port_fire[p]),
            .gate     (gate)
        );

        assign gate_o[p*NUM_TC +: NUM_TC] = gate;
    end

    gs_conflict #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_cfl (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (port_fire),
        .clr  (err_clr_i),
        .flag (conflict_o),
        .port (conflict_port_o)
    );
endmodule

// File: rtl/gate_sched_chk.sv
// Checker for gate_sched: relates run, gate events, clear and the outputs.
module gate_sched_chk #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PORTS-1:0]   run_i,
    input logic                   err_clr_i,
    input logic [NUM_PORTS-1:0]   fire,
    input logic [NUM_PORTS*8-1:0] gate_o,
    input logic                   conflict_o,
    input logic [PORT_W-1:0]      conflict_port_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            !run_i[p] |=> (gate_o[p*8 +: 8] == 8'hFF)); // R7
        AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (run_i[p] && !fire[p]) |=> $stable(gate_o[p*8 +: 8])); // R4
    end

    AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fire) > 1) |=> conflict_o); // R8
    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !err_clr_i) |=> conflict_o); // R8
    AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_o && !err_clr_i) |=> $stable(conflict_port_o)); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && ($countones(fire) < 2)) |=> !conflict_o); // R10
endmodule

bind gate_sched gate_sched_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run_i),
    .err_clr_i      (err_clr_i),
    .fire           (port_fire),
    .gate_o         (gate_o),
    .conflict_o     (conflict_o),
    .conflict_port_o(conflict_port_o)
);

// File: tb/gate_sched_tb.sv
module gate_sched_tb;
    localparam int NP = 3, DP = 4, TW = 32, DW = 20, IW = 2, PW = 2;

    logic clk = 0, rst_n = 0;
    logic [TW-1:0] time_i = 0;
    logic wr_en = 0;
    logic [PW-1:0] wr_port = 0;
    logic [IW-1:0] wr_idx = 0;
    logic [7:0] wr_mask = 0;
    logic [DW-1:0] wr_dur = 0;
    logic [NP-1:0] run = 0;
    logic [TW-1:0] base [NP];
    logic [IW-1:0] last [NP];
    logic err_clr = 0;
    logic [NP*TW-1:0] base_flat;
    logic [NP*IW-1:0] last_flat;
    logic [NP*8-1:0] gate_o;
    logic conflict_o;
    logic [PW-1:0] conflict_port_o;

    int total = 0, bad = 0, cycles = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_flat
        assign base_flat[p*TW +: TW] = base[p];
        assign last_flat[p*IW +: IW] = last[p];
    end

    gate_sched #(.NUM_PORTS(NP), .DEPTH(DP), .TIME_W(TW), .DUR_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .time_i(time_i),
        .wr_en_i(wr_en), .wr_port_i(wr_port), .wr_idx_i(wr_idx),
        .wr_mask_i(wr_mask), .wr_dur_i(wr_dur), .run_i(run),
        .base_time_i(base_flat), .last_idx_i(last_flat), .err_clr_i(err_clr),
        .gate_o(gate_o), .conflict_o(conflict_o), .conflict_port_o(conflict_port_o)
    );

    // Slot counter: one slot per clock in this bench.
    always @(negedge clk) if (rst_n) time_i <= time_i + 1;

    // Behavioural reference model.
    int m_mask [NP][DP];
    int m_dur  [NP][DP];
    bit m_run_started [NP];
    int m_idx [NP];
    longint m_end [NP];
    int m_gate [NP];
    bit m_err;
    int m_eport;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                for (int e = 0; e < DP; e++) begin m_mask[p][e] = 255; m_dur[p][e] = 0; end
                m_run_started[p] = 0; m_idx[p] = 0; m_end[p] = 0; m_gate[p] = 255;
            end
            m_err = 0; m_eport = 0;
        end else begin
            int fires; int lowp;
            fires = 0; lowp = -1;
            for (int p = 0; p < NP; p++) begin
                bit ev; int nx; longint org;
                ev = 0;
                if (!run[p]) begin
                    m_run_started[p] = 0; m_idx[p] = 0; m_gate[p] = 255; m_end[p] = 0;
                end else if (!m_run_started[p] && time_i >= base[p]) begin
                    ev = 1; nx = 0; org = base[p];
                end else if (m_run_started[p] && time_i >= m_end[p]) begin
                    ev = 1; org = m_end[p];
                    nx = (m_idx[p] == int'(last[p])) ? 0 : m_idx[p] + 1;
                end
                if (ev) begin
                    m_run_started[p] = 1; m_idx[p] = nx;
                    m_end[p] = org + ((m_dur[p][nx] == 0) ? 1 : m_dur[p][nx]);
                    m_gate[p] = m_mask[p][nx];
                    fires++;
                    if (lowp < 0) lowp = p;
                end
            end
            if (fires > 1) begin
                if (!m_err || err_clr) m_eport = lowp;
                m_err = 1;
            end else if (err_clr) m_err = 0;
            if (wr_en && int'(wr_port) < NP) begin
                m_mask[wr_port][wr_idx] = wr_mask;
                m_dur[wr_port][wr_idx] = wr_dur;
            end
        end
    end

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                total++;
                if (int'(gate_o[p*8 +: 8]) != m_gate[p]) begin
                    bad++;
                    $display("FAIL %s model gate p%0d t=%0d act=%h exp=%h", phase, p, time_i, gate_o[p*8 +: 8], m_gate[p]);
                end
            end
            total++;
            if (conflict_o != m_err || (m_err && int'(conflict_port_o) != m_eport)) begin
                bad++;
                $display("FAIL %s model conflict t=%0d act=%b/%0d exp=%b/%0d", phase, time_i, conflict_o, conflict_port_o, m_err, m_eport);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0d act=%h exp=%h", req, time_i, act, exp);
        end
    endtask

    task automatic wait_t(input int t);
        forever begin
            @(negedge clk); #1;
            if (int'(time_i) == t) break;
        end
    endtask

    task automatic wr(input int p, input int i, input int m, input int d);
        wr_en = 1; wr_port = PW'(p); wr_idx = IW'(i); wr_mask = 8'(m); wr_dur = DW'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    function automatic int g(input int p);
        return int'(gate_o[p*8 +: 8]);
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin base[p] = '0; last[p] = '0; end
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk("R1 gate p0", g(0), 'hFF);
        chk("R1 gate p2", g(2), 'hFF);
        chk("R1 conflict", conflict_o, 0);
        chk("R1 port", conflict_port_o, 0);

        phase = "R11";
        wr(0, 0, 'h80, 5); wr(0, 1, 'h7F, 20);
        wr(3, 0, 'h00, 9);               // R11: nonexistent port, ignored
        wr(1, 0, 'h01, 0); wr(1, 1, 'h02, 3); wr(1, 2, 'h04, 2);
        wr(2, 0, 'hAA, 4); wr(2, 1, 'h55, 4);
        last[0] = 1; last[1] = 2; last[2] = 1;
        base[0] = 100; run[0] = 1;

        phase = "R2";
        wait_t(60);  chk("R2 before base", g(0), 'hFF);
        wait_t(100); chk("R2 at base", g(0), 'hFF);
        phase = "R3";
        wait_t(101); chk("R3/R11 entry0", g(0), 'h80);
        phase = "R4";
        wait_t(105); chk("R4 hold", g(0), 'h80);
        wait_t(106); chk("R4 next", g(0), 'h7F);
        phase = "R5";
        wait_t(125); chk("R5 last", g(0), 'h7F);
        wait_t(126); chk("R5 wrap", g(0), 'h80);
        wait_t(131); chk("R5 second cycle", g(0), 'h7F);
        phase = "R7";
        wait_t(140); run[0] = 0;
        wait_t(141); chk("R7 stop", g(0), 'hFF);

        phase = "R6";
        base[1] = 200; run[1] = 1;
        wait_t(201); chk("R6 entry0", g(1), 'h01);
        wait_t(202); chk("R6 zero dur", g(1), 'h02);
        wait_t(205); chk("R6 entry2", g(1), 'h04);
        wait_t(207); chk("R6 wrap", g(1), 'h01);
        wait_t(210); chk("R8 no false flag", conflict_o, 0);
        wait_t(215); run[1] = 0;

        phase = "R8";
        wait_t(220); base[0] = 300; base[2] = 300; run[0] = 1; run[2] = 1;
        wait_t(301); chk("R8 flag", conflict_o, 1);
        chk("R9 port", conflict_port_o, 0);
        chk("R7 restart", g(0), 'h80);
        phase = "R9";
        wait_t(305); base[1] = 320; run[1] = 1;
        wait_t(322); chk("R9 held", conflict_port_o, 0);
        chk("R8 sticky", conflict_o, 1);

        phase = "R10";
        wait_t(340); run = '0;
        wait_t(345); err_clr = 1;
        wait_t(346); err_clr = 0;
        wait_t(347); chk("R10 cleared", conflict_o, 0);
        wait_t(350); base[1] = 380; base[2] = 380; run[1] = 1; run[2] = 1;
        wait_t(381); chk("R10 set", conflict_o, 1);
        chk("R10 port1", conflict_port_o, 1);
        wait_t(390); run = '0;
        wait_t(392); base[0] = 400; base[2] = 400; run[0] = 1; run[2] = 1;
        wait_t(400); err_clr = 1;
        wait_t(401); err_clr = 0;
        chk("R10 set wins", conflict_o, 1);
        chk("R10 relatch", conflict_port_o, 0);
        wait_t(420);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule